// File: doc/BRIEF.md
# Multi-mode capture timer/counter

This block is a pair of 8-bit counting halves that a 2-bit mode input rearranges into one of four shapes: two separate 8-bit timers, an 8-bit timer beside an 8-bit event counter, one 16-bit timer, or one 16-bit event counter. Timer halves advance on ticks from a shared 8-bit programmable prescaler. Event halves advance on rising edges of an external input after a two-flop synchronizer.

Each counting unit has a match value. When a count event arrives while the unit sits at its match value, the unit returns to zero and raises a sticky interrupt flag. Software clears that flag by pulsing the matching clear input. Capture strobes copy the running count into capture registers as wide as the active unit. In the 16-bit shapes, both bytes are copied in the same cycle.

Top module: `multi_capture_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it, both capture outputs read 0 and both interrupt flags read 0.
- R2: With prescaler reload value N, the prescaler gives one tick every N+1 clocks. After a mode change, the first tick comes N+1 clocks later. So the number of ticks taken by the edge j clocks after the change is floor((j-1)/(N+1)).
- R3: In mode 0 (mode_sel = 2'b00), both halves count prescaler ticks. The low half uses match_lo and sets irq_lo. The high half uses match_hi and sets irq_hi.
- R4: In mode 1 (mode_sel = 2'b01), the low half counts prescaler ticks and the high half counts synchronized rising edges of ev_in. A level held high counts only once.
- R5: In mode 2 (mode_sel = 2'b10), the halves form one 16-bit timer on prescaler ticks. The low byte carries into the high byte. The match value is {match_hi, match_lo}, a hit sets irq_lo, and irq_hi is never set.
- R6: In mode 3 (mode_sel = 2'b11), the halves form one 16-bit counter of synchronized rising edges of ev_in, with the same 16-bit match and flag rules as mode 2.
- R7: A count event that arrives while a unit equals its match value returns that unit to 0 and sets its flag. The flag stays set until a cycle with its clear input at 1; a match 0 keeps the unit at 0.
- R8: A capture strobe stores the count held before that same clock edge. In modes 0 and 1, cap_stb_lo loads only cap_lo and cap_stb_hi loads only cap_hi. In modes 2 and 3, cap_stb_lo loads both bytes together and cap_stb_hi has no effect.
- R9: A change of mode_sel clears both halves and the prescaler. Capture registers and interrupt flags keep their values across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Counting shape, encoded as in R3 to R6 |
| psc_reload | input | 8 | Prescaler reload value N |
| match_lo | input | 8 | Match value of the low half, or the low byte of the 16-bit match |
| match_hi | input | 8 | Match value of the high half, or the high byte of the 16-bit match |
| ev_in | input | 1 | External event input, asynchronous |
| cap_stb_lo | input | 1 | Capture strobe for the low half, or for both bytes in 16-bit modes |
| cap_stb_hi | input | 1 | Capture strobe for the high half |
| irq_clr_lo | input | 1 | Clear pulse for irq_lo |
| irq_clr_hi | input | 1 | Clear pulse for irq_hi |
| cap_lo | output | 8 | Low capture register |
| cap_hi | output | 8 | High capture register |
| irq_lo | output | 1 | Sticky match flag of the low half or of the 16-bit unit |
| irq_hi | output | 1 | Sticky match flag of the high half |

## Verification
Timer shapes are tried with reload values of 0, 1, 2, 4 and 255. These show whether tick spacing follows N+1 or is off by one, and whether the count resets on a mode change.

Match values are chosen so that the two halves wrap at different points in mode 0. In mode 2 the count runs past 0xFF, and a 16-bit match of 0x0100 is used. Together these separate a correct carry and wide compare from a byte-only compare.

Event shapes are driven with short pulses and with one long high level, which tells edge counting apart from level counting. A run of 260 events checks the 16-bit carry. Strobes on one side only show that capture is split per half in 8-bit shapes and joined in 16-bit shapes.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    MD_DUAL8   = 2'd0,
    MD_TMR_EVT = 2'd1,
    MD_TMR16   = 2'd2,
    MD_EVT16   = 2'd3
  } mct_mode_e;

  // Both halves joined into one wide unit.
  function automatic logic is_wide(mct_mode_e m);
    return (m == MD_TMR16) || (m == MD_EVT16);
  endfunction

  // Low half is fed by external edges instead of prescaler ticks.
  function automatic logic lo_counts_events(mct_mode_e m);
    return m == MD_EVT16;
  endfunction

  // High half is fed by external edges in its own right.
  function automatic logic hi_counts_events(mct_mode_e m);
    return m == MD_TMR_EVT;
  endfunction

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] reload,
  output logic          tick
);

  logic [PW-1:0] pc;

  function automatic logic [PW-1:0] pc_step(input logic [PW-1:0] c, input logic at_end);
    return at_end ? '0 : c + 1'b1;
  endfunction

  assign tick = (pc == reload);

  always_ff @(posedge clk) begin
    if (!rst_n)   pc <= '0;
    else if (clr) pc <= '0;
    else          pc <= pc_step(pc, tick);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload != '0) |=> (!tick || reload != $past(reload))); // R2

endmodule

// File: rtl/mct_edge_sync.sv
module mct_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_in};
  end

  assign rise = sh[1] & ~sh[2];

  AST_ONE_CYCLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R4

endmodule

// File: rtl/mct_half_counter.sv
module mct_half_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         to_zero,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  function automatic logic [W-1:0] next_val(input logic [W-1:0] c, input logic z, input logic i);
    if (z)      return '0;
    else if (i) return c + 1'b1;
    else        return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= next_val(cnt, to_zero, inc);
  end

endmodule

// File: rtl/multi_capture_timer.sv
module multi_capture_timer #(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [PSC_W-1:0]  psc_reload,
  input  logic [HALF_W-1:0] match_lo,
  input  logic [HALF_W-1:0] match_hi,
  input  logic              ev_in,
  input  logic              cap_stb_lo,
  input  logic              cap_stb_hi,
  input  logic              irq_clr_lo,
  input  logic              irq_clr_hi,
  output logic [HALF_W-1:0] cap_lo,
  output logic [HALF_W-1:0] cap_hi,
  output logic              irq_lo,
  output logic              irq_hi
);
  import mct_pkg::*;

  localparam int unsigned FULL_W = 2 * HALF_W;

  mct_mode_e         mode_q, mode_in;
  logic              mode_chg, wide;
  logic              ptick, ev_rise;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              inc_lo, inc_hi, hit16, hit_lo, hit_hi;
  logic              zero_lo, zero_hi, carry_lo;

  // Carry out of a byte that is about to step past its all-ones value.
  function automatic logic byte_carry(input logic [HALF_W-1:0] c, input logic i, input logic z);
    return i && !z && (c == {HALF_W{1'b1}});
  endfunction

  function automatic logic next_flag(input logic f, input logic set, input logic clr);
    return set | (f & ~clr);
  endfunction

  assign mode_in  = mct_mode_e'(mode_sel);
  assign mode_chg = (mode_in != mode_q);
  assign wide     = is_wide(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MD_DUAL8;
    else        mode_q <= mode_in;
  end

  mct_prescaler #(.PW(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .reload(psc_reload), .tick(ptick)
  );

  mct_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ev_in), .rise(ev_rise)
  );

  // Count sources per mode.
  assign inc_lo = !mode_chg && (lo_counts_events(mode_q) ? ev_rise : ptick);

  always_comb begin
    if (mode_chg)                    inc_hi = 1'b0;
    else if (wide)                   inc_hi = carry_lo;
    else if (hi_counts_events(mode_q)) inc_hi = ev_rise;
    else                             inc_hi = ptick;
  end

  // Match detection.
  assign hit16   = wide && inc_lo && ({cnt_hi, cnt_lo} == FULL_W'({match_hi, match_lo}));
  assign hit_lo  = wide ? hit16 : (inc_lo && cnt_lo == match_lo);
  assign hit_hi  = !wide && inc_hi && (cnt_hi == match_hi);
  assign zero_lo = hit_lo;
  assign zero_hi = wide ? hit16 : hit_hi;
  assign carry_lo = byte_carry(cnt_lo, inc_lo, zero_lo);

  mct_half_counter #(.W(HALF_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .to_zero(zero_lo), .inc(inc_lo), .cnt(cnt_lo)
  );

  mct_half_counter #(.W(HALF_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .to_zero(zero_hi), .inc(inc_hi), .cnt(cnt_hi)
  );

  // Sticky flags: a new hit wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= next_flag(irq_lo, hit_lo, irq_clr_lo);
      irq_hi <= next_flag(irq_hi, hit_hi, irq_clr_hi);
    end
  end

  // Capture registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else if (wide) begin
      if (cap_stb_lo) begin
        cap_lo <= cnt_lo;
        cap_hi <= cnt_hi;
      end
    end else begin
      if (cap_stb_lo) cap_lo <= cnt_lo;
      if (cap_stb_hi) cap_hi <= cnt_hi;
    end
  end

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt_lo == '0 && cnt_hi == '0)); // R9
  AST_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> (cnt_lo == '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !irq_clr_lo) |=> irq_lo); // R7
  AST_WIDE_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !irq_hi) |=> !irq_hi); // R5
  AST_CAP16_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && cap_stb_lo) |=> (cap_lo == $past(cnt_lo) && cap_hi == $past(cnt_hi))); // R8

endmodule

// File: tb/tb_multi_capture_timer.sv
module tb_multi_capture_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [7:0] psc_reload = 8'd0, match_lo = 8'hFF, match_hi = 8'hFF;
  logic       ev_in = 1'b0, cap_stb_lo = 1'b0, cap_stb_hi = 1'b0;
  logic       irq_clr_lo = 1'b0, irq_clr_hi = 1'b0;
  logic [7:0] cap_lo, cap_hi;
  logic       irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  multi_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .psc_reload(psc_reload),
    .match_lo(match_lo), .match_hi(match_hi), .ev_in(ev_in),
    .cap_stb_lo(cap_stb_lo), .cap_stb_hi(cap_stb_hi),
    .irq_clr_lo(irq_clr_lo), .irq_clr_hi(irq_clr_hi),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // mode, reload N, match_lo, match_hi, clocks j, expected cap_lo, cap_hi, irq_lo, irq_hi
  // Captured value = floor((j-1)/(N+1)) ticks folded by the match period; flags from floor(j/(N+1)).
  localparam logic [59:0] VEC [9] = '{
    {2'd0, 8'd0,   8'd255, 8'd255, 16'd10,  8'd9,    8'd9,    1'b0, 1'b0},
    {2'd0, 8'd2,   8'd3,   8'd255, 16'd20,  8'd2,    8'd6,    1'b1, 1'b0},
    {2'd0, 8'd4,   8'd255, 8'd1,   16'd31,  8'd6,    8'd0,    1'b0, 1'b1},
    {2'd1, 8'd1,   8'd255, 8'd0,   16'd9,   8'd4,    8'd0,    1'b0, 1'b0},
    {2'd2, 8'd0,   8'd255, 8'd255, 16'd300, 8'h2B,   8'h01,   1'b0, 1'b0},
    {2'd2, 8'd1,   8'd0,   8'd1,   16'd600, 8'h2A,   8'h00,   1'b1, 1'b0},
    {2'd3, 8'd0,   8'd255, 8'd255, 16'd50,  8'd0,    8'd0,    1'b0, 1'b0},
    {2'd0, 8'd0,   8'd0,   8'd255, 16'd5,   8'd0,    8'd4,    1'b1, 1'b0},
    {2'd0, 8'd255, 8'd255, 8'd255, 16'd600, 8'd2,    8'd2,    1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'd0:    return "R3 R2";
      2'd1:    return "R4 R2";
      2'd2:    return "R5 R2";
      default: return "R6";
    endcase
  endfunction

  task automatic run_vec(input logic [59:0] v);
    logic [1:0] m;
    string      rq;
    m  = v[59:58];
    rq = mode_req(m);
    @(negedge clk);
    mode_sel   = m ^ 2'b01;
    psc_reload = v[57:50];
    match_lo   = v[49:42];
    match_hi   = v[41:34];
    irq_clr_lo = 1'b1;
    irq_clr_hi = 1'b1;
    @(negedge clk);
    mode_sel   = m;
    irq_clr_lo = 1'b0;
    irq_clr_hi = 1'b0;
    repeat (v[33:18]) @(negedge clk);
    cap_stb_lo = 1'b1;
    cap_stb_hi = 1'b1;
    @(negedge clk);
    cap_stb_lo = 1'b0;
    cap_stb_hi = 1'b0;
    chk({rq, " R9 R8"}, "cap_lo", cap_lo, v[17:10]);
    chk({rq, " R9 R8"}, "cap_hi", cap_hi, v[9:2]);
    chk({rq, " R7"}, "irq_lo", irq_lo, v[1]);
    chk({rq, " R7"}, "irq_hi", irq_hi, v[0]);
  endtask

  task automatic ev_pulse();
    @(negedge clk); ev_in = 1'b1;
    @(negedge clk);
    @(negedge clk); ev_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "cap_lo in reset", cap_lo, 0);
    chk("R1", "irq_lo in reset", irq_lo, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cap_hi after reset", cap_hi, 0);
    chk("R1", "irq_hi after reset", irq_hi, 0);

    for (int i = 0; i < 9; i++) run_vec(VEC[i]);

    // R4: mode 1, high half counts edges; a long level counts once. Capture high only.
    @(negedge clk);
    mode_sel = 2'd1; match_hi = 8'hFF; match_lo = 8'hFF; psc_reload = 8'd3;
    repeat (5) ev_pulse();
    @(negedge clk); ev_in = 1'b1;
    repeat (10) @(negedge clk);
    ev_in = 1'b0;
    repeat (4) @(negedge clk);
    cap_stb_hi = 1'b1;
    @(negedge clk); cap_stb_hi = 1'b0;
    chk("R4", "cap_hi events", cap_hi, 6);
    chk("R8", "cap_lo untouched by hi strobe", cap_lo, 2);

    // R6: mode 3, 16-bit event counter with carry
    mode_sel = 2'd3;
    repeat (260) ev_pulse();
    cap_stb_lo = 1'b1;
    @(negedge clk); cap_stb_lo = 1'b0;
    chk("R6", "cap_lo 16-bit events", cap_lo, 8'h04);
    chk("R6", "cap_hi 16-bit events", cap_hi, 8'h01);

    // R8: high strobe ignored in wide mode; low strobe takes both bytes
    repeat (3) ev_pulse();
    cap_stb_hi = 1'b1;
    @(negedge clk); cap_stb_hi = 1'b0;
    @(negedge clk);
    chk("R8", "cap_lo after hi strobe in wide", cap_lo, 8'h04);
    chk("R8", "cap_hi after hi strobe in wide", cap_hi, 8'h01);
    cap_stb_lo = 1'b1;
    @(negedge clk); cap_stb_lo = 1'b0;
    chk("R8", "cap_lo atomic", cap_lo, 8'h07);
    chk("R8", "cap_hi atomic", cap_hi, 8'h01);

    // R7: match 0 sets flag; flag survives a mode change (R9) until cleared
    irq_clr_lo = 1'b1; irq_clr_hi = 1'b1;
    @(negedge clk);
    irq_clr_lo = 1'b0; irq_clr_hi = 1'b0;
    chk("R7", "irq_lo cleared", irq_lo, 0);
    mode_sel = 2'd0; psc_reload = 8'd0; match_lo = 8'd0; match_hi = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R7", "irq_lo set by match 0", irq_lo, 1);
    chk("R7", "irq_hi not set", irq_hi, 0);
    mode_sel = 2'd3;
    repeat (5) @(negedge clk);
    chk("R9", "irq_lo kept over mode change", irq_lo, 1);
    chk("R9", "cap_lo kept over mode change", cap_lo, 8'h07);
    irq_clr_lo = 1'b1;
    @(negedge clk); irq_clr_lo = 1'b0;
    chk("R7", "irq_lo after clear pulse", irq_lo, 0);
    repeat (3) @(negedge clk);
    chk("R7", "irq_lo stays clear", irq_lo, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule